// File: doc/BRIEF.md
# Checkpointed Rename Table with Shift-Chain Snapshots

This block is the mapping table of a superscalar rename stage. It is indexed by architectural register number, and each entry holds the physical register currently bound to that architectural register. Each cycle it takes a bundle of up to `LANES` instructions. For every lane it returns the physical names of both sources and the previous physical name of the destination, so that the reorder buffer can log it. It then installs the new destination mapping supplied by an external free list. Dependences inside the bundle are resolved in lane order. A source, or an old-destination read, that names a register written by an earlier lane of the same bundle sees that lane's new physical register. When two lanes write the same register, the later lane wins.

For recovery from misspeculation, the block keeps up to `DEPTH` whole-table snapshots in a chain behind the table. Taking a snapshot pushes every held snapshot one place further from the table and copies the table into the nearest slot. The copy includes the writes of the current bundle up to and including the lane chosen as the branch. Restoring snapshot k shifts the chain back toward the table once per cycle, so it takes k+1 cycles. On the last shift the table holds snapshot k. The shifts also remove snapshot k and every younger one. While a restore is in progress, `busy` is raised and rename input is discarded. The oldest snapshot can be released when its branch resolves.

Top module: `rename_snap_table`

## Requirements
- R1: Synchronous reset maps every architectural register i to physical register i. It also clears the snapshot count and drives `out_valid`, `busy` and `full` low. The snapshot count never exceeds `DEPTH`.
- R2: The source and old-destination physical names of lane l appear in field l (bits `[l*PHYS_W +: PHYS_W]`) of the output buses, with `out_valid[l]` set, one clock after the bundle is presented.
- R3: A valid lane with `lane_has_dst` set writes its `lane_new_phys` into its destination entry, and later bundles read the new value. A lane without a destination writes nothing.
- R4: Within a bundle, a lane's sources and old-destination read see the new mapping written by any earlier lane of the same bundle.
- R5: When several lanes of a bundle write the same destination, the highest-numbered lane's mapping is the one kept.
- R6: A push (`snap_push`) stores the table as it stands after the writes of lanes 0 through `snap_lane`. Writes of higher lanes are excluded. The snapshot count rises by one. Slot 0 is always the newest snapshot.
- R7: An accepted restore of slot k performs k+1 shifts on consecutive clocks, starting at the accepting edge. `busy` is high for the k cycles after acceptance. Every shift lowers the count by one. Afterwards the table equals snapshot k as it was pushed.
- R8: During the accepting cycle of a restore and while `busy` is high, rename input is ignored: `out_valid` is 0 on the next cycle and no table entry changes.
- R9: A push while the count equals `DEPTH` is refused. The count, `full` and all held snapshots stay unchanged.
- R10: A restore request whose index is not below the current count, or one raised while busy, is ignored.
- R11: `snap_release` drops the oldest snapshot, lowering the count by one (no effect at zero). A push and a release in the same cycle leave the count unchanged when the push is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lane_valid | input | LANES | Per-lane instruction present |
| lane_src_a | input | LANES*AW | First source register of each lane |
| lane_src_b | input | LANES*AW | Second source register of each lane |
| lane_dst | input | LANES*AW | Destination register of each lane |
| lane_has_dst | input | LANES | Lane writes a destination |
| lane_new_phys | input | LANES*PHYS_W | New physical register from the free list |
| snap_push | input | 1 | Take a snapshot this cycle |
| snap_lane | input | LW | Last lane whose write the snapshot includes |
| snap_release | input | 1 | Drop the oldest snapshot |
| restore_req | input | 1 | Start a restore |
| restore_idx | input | IW | Slot to restore, 0 = newest |
| out_valid | output | LANES | Registered lane valid for the returned names |
| out_src_a_phys | output | LANES*PHYS_W | Physical name of the first source |
| out_src_b_phys | output | LANES*PHYS_W | Physical name of the second source |
| out_old_dst_phys | output | LANES*PHYS_W | Previous mapping of the destination |
| busy | output | 1 | Multi-cycle restore in progress |
| full | output | 1 | All snapshot slots are occupied |
| snap_count | output | CW | Number of snapshots held |

## Verification
Renamed names come out of registers, so they are sampled on the falling edge that follows the rising edge that captured the bundle. That is one cycle after the inputs are driven. Effects on the table are checked on a later cycle by reading the entries back through a lane with no destination. Snapshot count, `full` and `busy` change at the edge that accepts a push, release or shift, so the bench reads them half a cycle after that edge. A restore of slot k is sampled on each of its following cycles: `busy` is high for exactly k samples, and contents are read back only once `busy` has fallen.

// File: rtl/rnm_pkg.sv
package rnm_pkg;
  localparam int DEF_ARCH_REGS = 64;
  localparam int DEF_PHYS_W    = 7;
  localparam int DEF_LANES     = 2;
  localparam int DEF_DEPTH     = 4;

  function automatic int bits_for(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/rnm_lane_stage.sv
// One lane of the bundle: reads from the table as left by earlier lanes,
// then produces the table with this lane's write applied.
module rnm_lane_stage #(
  parameter int ARCH_REGS = 64,
  parameter int PHYS_W    = 7,
  parameter int AW        = 6
) (
  input  logic [ARCH_REGS*PHYS_W-1:0] tbl_in,
  input  logic [AW-1:0]               src_a,
  input  logic [AW-1:0]               src_b,
  input  logic [AW-1:0]               dst,
  input  logic                        wr_en,
  input  logic [PHYS_W-1:0]           new_phys,
  output logic [ARCH_REGS*PHYS_W-1:0] tbl_out,
  output logic [PHYS_W-1:0]           a_phys,
  output logic [PHYS_W-1:0]           b_phys,
  output logic [PHYS_W-1:0]           old_phys
);
  always_comb begin
    a_phys   = tbl_in[int'(src_a)*PHYS_W +: PHYS_W];
    b_phys   = tbl_in[int'(src_b)*PHYS_W +: PHYS_W];
    old_phys = tbl_in[int'(dst)*PHYS_W +: PHYS_W];
    tbl_out  = tbl_in;
    if (wr_en) tbl_out[int'(dst)*PHYS_W +: PHYS_W] = new_phys;
  end
endmodule

// File: rtl/rnm_snap_ctrl.sv
// Tracks how many snapshots are held and sequences multi-cycle restores.
module rnm_snap_ctrl #(
  parameter int DEPTH = 4,
  parameter int IW    = 2,
  parameter int CW    = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_req,
  input  logic          rel_req,
  input  logic          restore_req,
  input  logic [IW-1:0] restore_idx,
  output logic          do_shift,
  output logic          do_push,
  output logic          busy,
  output logic          full,
  output logic [CW-1:0] count
);
  logic [IW-1:0] rem_q;
  logic [CW-1:0] cnt_q;
  logic          accept;
  logic          rel_ok;

  always_comb begin
    busy     = (rem_q != '0);
    full     = (cnt_q == CW'(DEPTH));
    accept   = restore_req && !busy && (CW'(restore_idx) < cnt_q);
    do_shift = accept || busy;
    do_push  = push_req && !do_shift && !full;
    rel_ok   = rel_req && !do_shift && (cnt_q != '0);
    count    = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0;
      cnt_q <= '0;
    end else begin
      if (accept)    rem_q <= restore_idx;
      else if (busy) rem_q <= rem_q - 1'b1;
      if (do_shift)  cnt_q <= cnt_q - 1'b1;
      else           cnt_q <= cnt_q + CW'(do_push) - CW'(rel_ok);
    end
  end
endmodule

// File: rtl/rename_snap_table.sv
module rename_snap_table
  import rnm_pkg::*;
#(
  parameter int ARCH_REGS = DEF_ARCH_REGS,
  parameter int PHYS_W    = DEF_PHYS_W,
  parameter int LANES     = DEF_LANES,
  parameter int DEPTH     = DEF_DEPTH,
  localparam int AW = $clog2(ARCH_REGS),
  localparam int LW = bits_for(LANES),
  localparam int IW = bits_for(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [LANES-1:0]        lane_valid,
  input  logic [LANES*AW-1:0]     lane_src_a,
  input  logic [LANES*AW-1:0]     lane_src_b,
  input  logic [LANES*AW-1:0]     lane_dst,
  input  logic [LANES-1:0]        lane_has_dst,
  input  logic [LANES*PHYS_W-1:0] lane_new_phys,
  input  logic                    snap_push,
  input  logic [LW-1:0]           snap_lane,
  input  logic                    snap_release,
  input  logic                    restore_req,
  input  logic [IW-1:0]           restore_idx,
  output logic [LANES-1:0]        out_valid,
  output logic [LANES*PHYS_W-1:0] out_src_a_phys,
  output logic [LANES*PHYS_W-1:0] out_src_b_phys,
  output logic [LANES*PHYS_W-1:0] out_old_dst_phys,
  output logic                    busy,
  output logic                    full,
  output logic [CW-1:0]           snap_count
);
  localparam int TW = ARCH_REGS * PHYS_W;

  function automatic logic [TW-1:0] ident_map();
    logic [TW-1:0] t;
    for (int i = 0; i < ARCH_REGS; i++) t[i*PHYS_W +: PHYS_W] = PHYS_W'(i);
    return t;
  endfunction
  localparam logic [TW-1:0] RESET_MAP = ident_map();

  logic [TW-1:0]     main_q;
  logic [TW-1:0]     snap_q [DEPTH];
  logic [TW-1:0]     stage  [LANES+1];
  logic [TW-1:0]     snap_src;
  logic [PHYS_W-1:0] rd_a [LANES];
  logic [PHYS_W-1:0] rd_b [LANES];
  logic [PHYS_W-1:0] rd_o [LANES];
  logic              do_shift, do_push, rn_en;

  rnm_snap_ctrl #(.DEPTH(DEPTH), .IW(IW), .CW(CW)) u_ctrl (
    .clk(clk), .rst(rst), .push_req(snap_push), .rel_req(snap_release),
    .restore_req(restore_req), .restore_idx(restore_idx),
    .do_shift(do_shift), .do_push(do_push), .busy(busy), .full(full),
    .count(snap_count)
  );

  assign rn_en    = !do_shift;
  assign stage[0] = main_q;

  // Lanes chained in program order: later lanes see earlier writes.
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    rnm_lane_stage #(.ARCH_REGS(ARCH_REGS), .PHYS_W(PHYS_W), .AW(AW)) u_stage (
      .tbl_in(stage[l]),
      .src_a(lane_src_a[l*AW +: AW]),
      .src_b(lane_src_b[l*AW +: AW]),
      .dst(lane_dst[l*AW +: AW]),
      .wr_en(rn_en && lane_valid[l] && lane_has_dst[l]),
      .new_phys(lane_new_phys[l*PHYS_W +: PHYS_W]),
      .tbl_out(stage[l+1]),
      .a_phys(rd_a[l]), .b_phys(rd_b[l]), .old_phys(rd_o[l])
    );
  end

  always_comb begin
    snap_src = stage[LANES];
    for (int l = 0; l < LANES; l++)
      if (int'(snap_lane) == l) snap_src = stage[l+1];
  end

  always_ff @(posedge clk) begin
    if (rst)           main_q <= RESET_MAP;
    else if (do_shift) main_q <= snap_q[0];
    else               main_q <= stage[LANES];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < DEPTH; k++) snap_q[k] <= '0;
    end else if (do_push) begin
      snap_q[0] <= snap_src;
      for (int k = 1; k < DEPTH; k++) snap_q[k] <= snap_q[k-1];
    end else if (do_shift) begin
      for (int k = 0; k < DEPTH - 1; k++) snap_q[k] <= snap_q[k+1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid        <= '0;
      out_src_a_phys   <= '0;
      out_src_b_phys   <= '0;
      out_old_dst_phys <= '0;
    end else begin
      out_valid <= rn_en ? lane_valid : '0;
      for (int l = 0; l < LANES; l++) begin
        out_src_a_phys[l*PHYS_W +: PHYS_W]   <= rd_a[l];
        out_src_b_phys[l*PHYS_W +: PHYS_W]   <= rd_b[l];
        out_old_dst_phys[l*PHYS_W +: PHYS_W] <= rd_o[l];
      end
    end
  end
endmodule

// File: rtl/rnm_snap_chk.sv
module rnm_snap_chk #(
  parameter int LANES = 2,
  parameter int DEPTH = 4,
  parameter int IW    = 2,
  parameter int CW    = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             restore_req,
  input logic [IW-1:0]    restore_idx,
  input logic             snap_push,
  input logic             snap_release,
  input logic             busy,
  input logic             full,
  input logic [CW-1:0]    snap_count,
  input logic [LANES-1:0] out_valid
);
  // R1
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    snap_count <= CW'(DEPTH));

  // R7
  restore_start_chk: assert property (@(posedge clk) disable iff (rst)
    (restore_req && !busy && (CW'(restore_idx) < snap_count))
      |=> (busy == ($past(restore_idx) != '0)));

  // R7
  shift_pop_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> (snap_count == $past(snap_count) - 1'b1));

  // R8
  stall_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> (out_valid == '0));

  // R9
  full_refuse_chk: assert property (@(posedge clk) disable iff (rst)
    (full && snap_push && !snap_release && !busy && !restore_req)
      |=> (full && snap_count == $past(snap_count)));

  // R10
  bad_restore_chk: assert property (@(posedge clk) disable iff (rst)
    (restore_req && !busy && (CW'(restore_idx) >= snap_count) && !snap_push && !snap_release)
      |=> (!busy && snap_count == $past(snap_count)));
endmodule

bind rename_snap_table rnm_snap_chk #(.LANES(LANES), .DEPTH(DEPTH), .IW(IW), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .restore_req(restore_req), .restore_idx(restore_idx),
  .snap_push(snap_push), .snap_release(snap_release), .busy(busy), .full(full),
  .snap_count(snap_count), .out_valid(out_valid)
);

// File: tb/test_rename_snap_table.sv
module test_rename_snap_table;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6, PW = 7, LANES = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic [LANES-1:0]    lane_valid = '0, lane_has_dst = '0;
  logic [LANES*AW-1:0] lane_src_a = '0, lane_src_b = '0, lane_dst = '0;
  logic [LANES*PW-1:0] lane_new_phys = '0;
  logic snap_push = 0, snap_release = 0, restore_req = 0;
  logic [0:0] snap_lane = '0;
  logic [1:0] restore_idx = '0;
  logic [LANES-1:0] out_valid;
  logic [LANES*PW-1:0] out_src_a_phys, out_src_b_phys, out_old_dst_phys;
  logic busy, full;
  logic [2:0] snap_count;

  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rename_snap_table i_rename_snap_table (
    .clk(clk), .rst(rst), .lane_valid(lane_valid), .lane_src_a(lane_src_a),
    .lane_src_b(lane_src_b), .lane_dst(lane_dst), .lane_has_dst(lane_has_dst),
    .lane_new_phys(lane_new_phys), .snap_push(snap_push), .snap_lane(snap_lane),
    .snap_release(snap_release), .restore_req(restore_req), .restore_idx(restore_idx),
    .out_valid(out_valid), .out_src_a_phys(out_src_a_phys), .out_src_b_phys(out_src_b_phys),
    .out_old_dst_phys(out_old_dst_phys), .busy(busy), .full(full), .snap_count(snap_count)
  );

  typedef struct packed {
    logic [5:0] a0, b0, d0; logic w0; logic [6:0] n0;
    logic [5:0] a1, b1, d1; logic w1; logic [6:0] n1;
    logic [6:0] ea0, eb0, eo0, ea1, eb1, eo1;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{6'd1, 6'd2, 6'd3, 1'b1, 7'd100, 6'd3, 6'd4, 6'd5, 1'b1, 7'd101,
      7'd1, 7'd2, 7'd3, 7'd100, 7'd4, 7'd5},
    '{6'd3, 6'd5, 6'd3, 1'b1, 7'd102, 6'd3, 6'd7, 6'd3, 1'b1, 7'd103,
      7'd100, 7'd101, 7'd100, 7'd102, 7'd7, 7'd102},
    '{6'd3, 6'd63, 6'd0, 1'b0, 7'd0, 6'd0, 6'd5, 6'd63, 1'b1, 7'd104,
      7'd103, 7'd63, 7'd0, 7'd0, 7'd101, 7'd63},
    '{6'd63, 6'd0, 6'd10, 1'b1, 7'd105, 6'd10, 6'd10, 6'd10, 1'b1, 7'd106,
      7'd104, 7'd0, 7'd10, 7'd105, 7'd105, 7'd105}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle();
    lane_valid = '0; lane_has_dst = '0; lane_src_a = '0; lane_src_b = '0;
    lane_dst = '0; lane_new_phys = '0; snap_push = 0; snap_release = 0;
    restore_req = 0; restore_idx = '0; snap_lane = '0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic set_lane(input int l, input int a, input int b, input int d,
                          input bit w, input int n);
    lane_valid[l]   = 1'b1;
    lane_has_dst[l] = w;
    lane_src_a[l*AW +: AW]    = AW'(a);
    lane_src_b[l*AW +: AW]    = AW'(b);
    lane_dst[l*AW +: AW]      = AW'(d);
    lane_new_phys[l*PW +: PW] = PW'(n);
  endtask

  // Reads two entries through lane 0 without writing.
  task automatic rd(input string req, input int r0, input int r1, input int e0, input int e1);
    idle();
    set_lane(0, r0, r1, 0, 1'b0, 0);
    step();
    chk(req, int'(out_src_a_phys[PW-1:0]), e0);
    chk(req, int'(out_src_b_phys[PW-1:0]), e1);
    idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    idle();
    rst = 1'b1;
    repeat (3) step();
    rst = 1'b0;
    // R1: reset state
    chk("R1 out_valid", int'(out_valid), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 full", int'(full), 0);
    chk("R1 count", int'(snap_count), 0);
    rd("R1 identity", 20, 40, 20, 40);
    rd("R1 identity", 0, 63, 0, 63);

    // R2 R3 R4 R5: vector table of two-lane bundles
    for (int i = 0; i < 4; i++) begin
      idle();
      set_lane(0, VECS[i].a0, VECS[i].b0, VECS[i].d0, VECS[i].w0, VECS[i].n0);
      set_lane(1, VECS[i].a1, VECS[i].b1, VECS[i].d1, VECS[i].w1, VECS[i].n1);
      step();
      chk("R2 valid", int'(out_valid), 3);
      chk("R2 lane0 a", int'(out_src_a_phys[0 +: PW]), VECS[i].ea0);
      chk("R2 lane0 b", int'(out_src_b_phys[0 +: PW]), VECS[i].eb0);
      chk("R2 lane0 old", int'(out_old_dst_phys[0 +: PW]), VECS[i].eo0);
      chk("R4 lane1 a", int'(out_src_a_phys[PW +: PW]), VECS[i].ea1);
      chk("R4 lane1 b", int'(out_src_b_phys[PW +: PW]), VECS[i].eb1);
      chk("R4 lane1 old", int'(out_old_dst_phys[PW +: PW]), VECS[i].eo1);
    end
    idle();
    // R3 R5: final contents after the table
    rd("R3 written", 3, 5, 103, 101);
    rd("R5 later lane", 10, 63, 106, 104);

    // R6: mid-bundle push at lane 0
    idle();
    set_lane(0, 0, 0, 20, 1'b1, 110);
    set_lane(1, 0, 0, 21, 1'b1, 111);
    snap_push = 1; snap_lane = 1'b0;
    step();
    chk("R6 count", int'(snap_count), 1);
    idle(); set_lane(0, 0, 0, 20, 1'b1, 112); set_lane(1, 0, 0, 21, 1'b1, 113); step();
    idle(); snap_push = 1; step();
    chk("R6 count", int'(snap_count), 2);
    idle(); set_lane(0, 0, 0, 20, 1'b1, 114); step();
    idle(); snap_push = 1; step();
    idle(); set_lane(0, 0, 0, 20, 1'b1, 115); snap_push = 1; step();
    chk("R9 count at full", int'(snap_count), 4);
    chk("R9 full", int'(full), 1);
    // R9: refused push while full
    idle(); set_lane(0, 0, 0, 21, 1'b1, 116); snap_push = 1; step();
    chk("R9 count kept", int'(snap_count), 4);
    chk("R9 full kept", int'(full), 1);

    // R7 R8: restore slot 2 with rename input present throughout
    idle(); set_lane(0, 0, 0, 20, 1'b1, 120); restore_req = 1; restore_idx = 2'd2; step();
    chk("R7 busy 1", int'(busy), 1);
    chk("R8 stalled", int'(out_valid), 0);
    idle(); set_lane(0, 0, 0, 20, 1'b1, 121); step();
    chk("R7 busy 2", int'(busy), 1);
    chk("R8 stalled", int'(out_valid), 0);
    step();
    chk("R7 busy end", int'(busy), 0);
    chk("R8 stalled", int'(out_valid), 0);
    idle();
    chk("R7 count", int'(snap_count), 1);
    rd("R7 R8 R9 restored", 20, 21, 112, 113);

    // R10: index beyond count is ignored
    idle(); restore_req = 1; restore_idx = 2'd1; step();
    chk("R10 busy", int'(busy), 0);
    chk("R10 count", int'(snap_count), 1);
    rd("R10 table kept", 20, 21, 112, 113);

    // R6 R7: restore newest in a single shift; lane 1 write excluded
    idle(); restore_req = 1; restore_idx = 2'd0; step();
    chk("R7 one shift", int'(busy), 0);
    chk("R7 count", int'(snap_count), 0);
    rd("R6 mid-bundle", 20, 21, 110, 21);

    // R11: release and simultaneous push/release
    idle(); snap_push = 1; step();
    idle(); snap_push = 1; step();
    chk("R11 count", int'(snap_count), 2);
    idle(); snap_release = 1; step();
    chk("R11 release", int'(snap_count), 1);
    idle(); snap_release = 1; snap_push = 1; step();
    chk("R11 push+release", int'(snap_count), 1);
    idle();

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule